// File: doc/BRIEF.md
# Serial Disk Write Serializer with CRC Append

This block turns host bytes into the bit stream stored on a serial-bit disk. One bit leaves per bit-time strobe, least significant bit first. A double-buffered data path lets the host place the next byte in a holding latch while the current byte shifts out. At every byte boundary the block raises a byte-ready flag, and an interrupt if interrupts are enabled. Until the host starts a transfer, each bit time stores a zero, which lays down the gap in front of a block.

To close a block, the host sets the CRC-append control bit while the last data byte is going out. From the next byte boundary, the block shifts out the running reflected CCITT CRC-16 (polynomial 0x8408, preset zero), low byte first. Accumulation stops once the first CRC byte is loaded. The append request clears itself at the boundary where the remainder reaches zero. At that boundary the data latch is also cleared, so zeros follow. A write-protected disk or read mode suppresses storing and freezes the bit position. The disk memory and the drive mechanics sit outside the block.

Top module: `disk_write_serializer`

## Requirements
- R1: After reset, byte_ready, irq and crc_req are low and no store strobe is active.
- R2: Before a start, every bit strobe in write mode without write protection gives a one-cycle wr_stb with wr_bit 0.
- R3: A control write with ctrl_go 1 while the stored go bit is 0 and ctrl_read 0 starts a transfer. It loads the shifter from the data latch, sets byte_ready, clears the CRC and enables accumulation. The same write with ctrl_read 1 starts nothing.
- R4: A data write stores data_in in the latch and clears byte_ready.
- R5: In a transfer, the k-th strobe of a byte outputs bit k of that byte on wr_bit (bit 0 first). After the last bit, the shifter reloads from the latch and byte_ready is set.
- R6: At a byte boundary irq is set if the stored interrupt-enable bit is 1. Any control write clears irq.
- R7: While accumulation is on, every emitted bit advances the CRC (x^16+x^12+x^5+1, reflected, preset zero). With crc_req set at a boundary, the next byte is the CRC low byte, then the high byte, and accumulation stops.
- R8: At a boundary with crc_req set and the updated remainder zero, crc_req clears and the data latch is zeroed. The bytes after the CRC are zero.
- R9: A bit strobe while wr_protect is 1 gives no wr_stb and does not move the bit position.
- R10: A bit strobe while the stored read bit is 1 gives no wr_stb and does not move the bit position.
- R11: A control write with ctrl_go 0 ends the transfer. Later strobes store zeros even with a non-zero latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle bit-time strobe |
| wr_protect | input | 1 | Disk is write protected |
| data_we | input | 1 | Write the data latch |
| data_in | input | DATA_W | Byte for the data latch |
| ctrl_we | input | 1 | Write the control bits |
| ctrl_read | input | 1 | Read mode (1) or write mode (0) |
| ctrl_crc | input | 1 | Request CRC append |
| ctrl_go | input | 1 | Transfer enable; a rising value starts |
| ctrl_ien | input | 1 | Interrupt enable |
| wr_bit | output | 1 | Bit to store |
| wr_stb | output | 1 | Store enable, one cycle per stored bit |
| byte_ready | output | 1 | Byte boundary reached, latch may be refilled |
| irq | output | 1 | Interrupt request |
| crc_req | output | 1 | CRC append request still pending |

## Verification
The hardest case to reach is the self-clear of the append request. It needs a long accumulated stream and a request raised mid-byte. The high CRC byte then has to leave before the remainder becomes zero. The stimulus sends a full 256-byte sweep and sets the request while the last byte is still in the latch. It then checks the CRC bytes against a CRC computed in the bench, the fall of crc_req after the high byte, and the zero bytes that prove the latch was cleared. A second run breaks bytes with write-protect and read-mode strobes, and a third starts and requests the CRC in the same write.

// File: rtl/wser_pkg.sv
package wser_pkg;

   typedef struct packed {
      logic ien;
      logic go;
      logic crc;
      logic rd;
   } wser_ctrl_t;

endpackage

// File: rtl/wser_ctrl_reg.sv
module wser_ctrl_reg
   import wser_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  wser_ctrl_t din,
   input  logic       crc_done,
   output wser_ctrl_t ctrl_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (we) begin
         ctrl_q <= din;
      end else if (crc_done) begin
         ctrl_q.crc <= 1'b0;
      end
   end

endmodule

// File: rtl/wser_crc_unit.sv
module wser_crc_unit #(
   parameter int unsigned     CRC_W  = 16,
   parameter int unsigned     DATA_W = 8,
   parameter logic [CRC_W-1:0] POLY  = 16'h8408
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             shift_en,
   input  logic             append,
   input  logic             din,
   output logic [CRC_W-1:0] crc_upd
);

   logic [CRC_W-1:0] crc_q;
   logic             acc_q;

   function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c, input logic b);
      logic fb;
      fb   = c[0] ^ b;
      step = (c >> 1) ^ (fb ? POLY : '0);
   endfunction

   assign crc_upd = acc_q ? step(crc_q, din) : crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q <= '0;
         acc_q <= 1'b0;
      end else if (start) begin
         crc_q <= '0;
         acc_q <= 1'b1;
      end else if (shift_en) begin
         if (append) begin
            crc_q <= crc_upd >> DATA_W;
            acc_q <= 1'b0;
         end else begin
            crc_q <= crc_upd;
         end
      end
   end

endmodule

// File: rtl/wser_shifter.sv
module wser_shifter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_we,
   input  logic [DATA_W-1:0] data_in,
   input  logic              start,
   input  logic              shift_en,
   input  logic              load_crc,
   input  logic              clr_latch,
   input  logic [DATA_W-1:0] crc_byte,
   output logic              cur_bit,
   output logic              last_bit
);

   localparam int unsigned    IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   logic [DATA_W-1:0] latch_q;
   logic [DATA_W-1:0] shreg_q;
   logic [IDX_W-1:0]  idx_q;

   assign cur_bit  = shreg_q[idx_q];
   assign last_bit = (idx_q == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '0;
         shreg_q <= '0;
         idx_q   <= '0;
      end else begin
         if (data_we) begin
            latch_q <= data_in;
         end else if (clr_latch) begin
            latch_q <= '0;
         end
         if (start) begin
            shreg_q <= latch_q;
            idx_q   <= '0;
         end else if (shift_en) begin
            if (last_bit) begin
               idx_q   <= '0;
               shreg_q <= load_crc ? crc_byte : latch_q;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/disk_write_serializer.sv
module disk_write_serializer
   import wser_pkg::*;
#(
   parameter int unsigned      DATA_W  = 8,
   parameter int unsigned      CRC_W   = 16,
   parameter logic [CRC_W-1:0] POLY    = 16'h8408,
   parameter bit               OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              wr_protect,
   input  logic              data_we,
   input  logic [DATA_W-1:0] data_in,
   input  logic              ctrl_we,
   input  logic              ctrl_read,
   input  logic              ctrl_crc,
   input  logic              ctrl_go,
   input  logic              ctrl_ien,
   output logic              wr_bit,
   output logic              wr_stb,
   output logic              byte_ready,
   output logic              irq,
   output logic              crc_req
);

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("DATA_W must be at least 2");
      end
      if (CRC_W < DATA_W || (CRC_W % DATA_W) != 0) begin : g_bad_crc_w
         $error("CRC_W must be a whole multiple of DATA_W");
      end
      if (POLY == '0) begin : g_bad_poly
         $error("POLY must be non-zero");
      end
   endgenerate

   wser_ctrl_t       ctrl_d;
   wser_ctrl_t       ctrl_q;
   logic             started_q;
   logic             start_edge;
   logic             stop_req;
   logic             active;
   logic             shift_en;
   logic             last_bit;
   logic             boundary;
   logic             append;
   logic             crc_done;
   logic             cur_bit;
   logic [CRC_W-1:0] crc_upd;
   logic             stb_d;
   logic             bit_d;

   assign ctrl_d     = '{ien: ctrl_ien, go: ctrl_go, crc: ctrl_crc, rd: ctrl_read};
   assign start_edge = ctrl_we & ctrl_go & ~ctrl_q.go & ~ctrl_read;
   assign stop_req   = ctrl_we & ~ctrl_go;
   assign active     = bit_tick & ~ctrl_q.rd & ~wr_protect;
   assign shift_en   = active & started_q;
   assign boundary   = shift_en & last_bit;
   assign append     = boundary & ctrl_q.crc;
   assign crc_done   = append & (crc_upd == '0);
   assign crc_req    = ctrl_q.crc;

   wser_ctrl_reg i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (ctrl_we),
      .din      (ctrl_d),
      .crc_done (crc_done),
      .ctrl_q   (ctrl_q)
   );

   wser_crc_unit #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) i_crc (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_edge),
      .shift_en (shift_en),
      .append   (append),
      .din      (cur_bit),
      .crc_upd  (crc_upd)
   );

   wser_shifter #(.DATA_W(DATA_W)) i_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .data_we   (data_we),
      .data_in   (data_in),
      .start     (start_edge),
      .shift_en  (shift_en),
      .load_crc  (append),
      .clr_latch (crc_done),
      .crc_byte  (crc_upd[DATA_W-1:0]),
      .cur_bit   (cur_bit),
      .last_bit  (last_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         started_q  <= 1'b0;
         byte_ready <= 1'b0;
         irq        <= 1'b0;
      end else begin
         if (start_edge) begin
            started_q <= 1'b1;
         end else if (stop_req) begin
            started_q <= 1'b0;
         end
         if (start_edge || boundary) begin
            byte_ready <= 1'b1;
         end else if (data_we) begin
            byte_ready <= 1'b0;
         end
         if (boundary && ctrl_q.ien) begin
            irq <= 1'b1;
         end else if (ctrl_we) begin
            irq <= 1'b0;
         end
      end
   end

   assign stb_d = active;
   assign bit_d = shift_en & cur_bit;

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr_stb <= 1'b0;
               wr_bit <= 1'b0;
            end else begin
               wr_stb <= stb_d;
               wr_bit <= bit_d;
            end
         end
      end else begin : g_out_comb
         assign wr_stb = stb_d;
         assign wr_bit = bit_d;
      end
   endgenerate

endmodule

// File: rtl/wser_checker.sv
module wser_checker #(
   parameter bit OUT_REG = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic bit_tick,
   input logic wr_protect,
   input logic data_we,
   input logic ctrl_we,
   input logic wr_bit,
   input logic wr_stb,
   input logic byte_ready,
   input logic irq,
   input logic crc_req,
   input logic rd_mode,
   input logic irq_en
);

   AST_BIT_ONLY_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
      wr_bit |-> wr_stb); // R5

   AST_DATA_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && !bit_tick && !ctrl_we) |=> !byte_ready); // R4

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(irq_en)); // R6

   AST_CRC_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(crc_req) |-> $past(ctrl_we || bit_tick)); // R8

   generate
      if (OUT_REG) begin : g_reg_checks
         AST_PROTECT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
            wr_stb |-> $past(bit_tick && !wr_protect)); // R9

         AST_READ_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
            wr_stb |-> $past(!rd_mode)); // R10
      end
   endgenerate

endmodule

bind disk_write_serializer wser_checker #(.OUT_REG(OUT_REG)) i_wser_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .bit_tick   (bit_tick),
   .wr_protect (wr_protect),
   .data_we    (data_we),
   .ctrl_we    (ctrl_we),
   .wr_bit     (wr_bit),
   .wr_stb     (wr_stb),
   .byte_ready (byte_ready),
   .irq        (irq),
   .crc_req    (crc_req),
   .rd_mode    (ctrl_q.rd),
   .irq_en     (ctrl_q.ien)
);

// File: tb/test_disk_write_serializer.sv
module test_disk_write_serializer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       wr_protect = 1'b0;
   logic       data_we = 1'b0;
   logic [7:0] data_in = '0;
   logic       ctrl_we = 1'b0;
   logic       ctrl_read = 1'b0;
   logic       ctrl_crc = 1'b0;
   logic       ctrl_go = 1'b0;
   logic       ctrl_ien = 1'b0;
   logic       wr_bit;
   logic       wr_stb;
   logic       byte_ready;
   logic       irq;
   logic       crc_req;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   disk_write_serializer i_disk_write_serializer (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_protect(wr_protect),
      .data_we(data_we), .data_in(data_in), .ctrl_we(ctrl_we),
      .ctrl_read(ctrl_read), .ctrl_crc(ctrl_crc), .ctrl_go(ctrl_go), .ctrl_ien(ctrl_ien),
      .wr_bit(wr_bit), .wr_stb(wr_stb), .byte_ready(byte_ready), .irq(irq), .crc_req(crc_req)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c;
      for (int k = 0; k < 8; k++) begin
         if (r[0] ^ b[k]) r = (r >> 1) ^ 16'h8408;
         else             r = r >> 1;
      end
      return r;
   endfunction

   task automatic tick(output logic s, output logic b);
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
      s = wr_stb;
      b = wr_bit;
   endtask

   task automatic get_byte(input string req, input int exp);
      logic [7:0] v;
      int         n;
      logic       s, b;
      n = 0;
      for (int k = 0; k < 8; k++) begin
         tick(s, b);
         v[k] = b;
         n += int'(s);
      end
      chk(req, int'(v), exp);
      chk({req, " strobes"}, n, 8);
   endtask

   task automatic wdata(input logic [7:0] v);
      @(negedge clk) begin data_we = 1'b1; data_in = v; end
      @(negedge clk) data_we = 1'b0;
   endtask

   task automatic wctrl(input logic rd, input logic crc, input logic go, input logic ien);
      @(negedge clk) begin
         ctrl_we = 1'b1; ctrl_read = rd; ctrl_crc = crc; ctrl_go = go; ctrl_ien = ien;
      end
      @(negedge clk) ctrl_we = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] crc;
      logic        s, b;
      logic [7:0]  v, bits;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 byte_ready", int'(byte_ready), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 crc_req", int'(crc_req), 0);
      chk("R1 wr_stb", int'(wr_stb), 0);
      // R2 gap zeros before start
      get_byte("R2 gap byte 0", 0);
      get_byte("R2 gap byte 1", 0);

      // Run A: full byte sweep, interrupts on
      wdata(8'h00);
      wctrl(1'b0, 1'b0, 1'b1, 1'b1);
      chk("R3 byte_ready after start", int'(byte_ready), 1);
      crc = '0;
      for (int i = 0; i < 256; i++) begin
         if (i < 255) begin
            wdata(8'(i + 1));
            chk("R4 data write clears byte_ready", int'(byte_ready), 0);
         end else begin
            wctrl(1'b0, 1'b1, 1'b1, 1'b1);
            chk("R6 control write clears irq", int'(irq), 0);
            chk("R7 crc_req set", int'(crc_req), 1);
         end
         get_byte("R5 sweep byte", i);
         chk("R5 byte_ready at boundary", int'(byte_ready), 1);
         chk("R6 irq at boundary", int'(irq), 1);
         crc = crc_byte(crc, 8'(i));
      end
      get_byte("R7 crc low byte", int'(crc[7:0]));
      if (crc[15:8] != 8'h00) chk("R8 crc_req held before zero", int'(crc_req), 1);
      get_byte("R7 crc high byte", int'(crc[15:8]));
      chk("R8 crc_req self-cleared", int'(crc_req), 0);
      get_byte("R8 zero after crc", 0);
      get_byte("R8 latch zeroed", 0);

      // R11 stop: zeros despite non-zero latch
      wctrl(1'b0, 1'b0, 1'b0, 1'b1);
      wdata(8'hA5);
      get_byte("R11 stopped byte 0", 0);
      get_byte("R11 stopped byte 1", 0);

      // Run B: interrupts off, protect and read-mode strobes inside bytes
      crc = '0;
      wdata(8'd5);
      wctrl(1'b0, 1'b0, 1'b1, 1'b0);
      for (int i = 0; i < 16; i++) begin
         logic crq;
         crq = (i == 15);
         if (i < 15) wdata(8'((i + 1) * 37 + 5));
         else        wctrl(1'b0, 1'b1, 1'b1, 1'b0);
         v = 8'(i * 37 + 5);
         for (int k = 0; k < 8; k++) begin
            if (k == 3) begin
               wr_protect = 1'b1;
               tick(s, b);
               chk("R9 no store when protected", int'(s), 0);
               wr_protect = 1'b0;
            end
            if (k == 5) begin
               wctrl(1'b1, crq, 1'b1, 1'b0);
               tick(s, b);
               chk("R10 no store in read mode", int'(s), 0);
               wctrl(1'b0, crq, 1'b1, 1'b0);
            end
            tick(s, b);
            bits[k] = b;
         end
         chk("R9 R10 byte intact across pauses", int'(bits), int'(v));
         chk("R6 irq stays low when disabled", int'(irq), 0);
         crc = crc_byte(crc, v);
      end
      get_byte("R7 run B crc low", int'(crc[7:0]));
      get_byte("R7 run B crc high", int'(crc[15:8]));
      chk("R8 run B crc_req cleared", int'(crc_req), 0);
      get_byte("R8 run B zero", 0);

      // R3 go edge in read mode starts nothing
      wctrl(1'b0, 1'b0, 1'b0, 1'b0);
      wdata(8'h5A);
      wctrl(1'b1, 1'b0, 1'b1, 1'b0);
      wctrl(1'b0, 1'b0, 1'b1, 1'b0);
      get_byte("R3 no start from read mode", 0);

      // Run C: start and append requested in one write
      wctrl(1'b0, 1'b0, 1'b0, 1'b0);
      wdata(8'h96);
      wctrl(1'b0, 1'b1, 1'b1, 1'b1);
      chk("R3 run C byte_ready", int'(byte_ready), 1);
      crc = crc_byte(16'h0000, 8'h96);
      get_byte("R5 run C data", 8'h96);
      get_byte("R7 run C crc low", int'(crc[7:0]));
      get_byte("R7 run C crc high", int'(crc[15:8]));
      chk("R8 run C crc_req cleared", int'(crc_req), 0);
      get_byte("R8 run C zero", 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule